// File: doc/BRIEF.md
# Strobed Windowed-Write Watchdog Timer

This block is a programmable watchdog. A slow tick enable (nominally 32 Hz, so one tick every 31.25 ms) drives a down-counter. If software does not strobe the block within the programmed number of tick periods, it emits a timeout pulse. A flag or interrupt controller downstream consumes that pulse and decides whether an interrupt line is asserted.

Software reaches the block through one byte-wide control register. Bit 7 is a write-only reload strobe that clears itself. Bit 6 is a protect bit for the timeout field. Bits 5:0 hold the timeout in tick periods. A protected write can strobe the watchdog without disturbing its timeout. A new timeout value is first staged and only takes effect at the next tick. A timeout of zero switches the watchdog off.

Top module: `wdog_strobed`

## Requirements
- R1: After reset the register reads 0x40 (protect bit 6 set, timeout field bits 5:0 equal to zero) and `timeout_o` is low.
- R2: While the timeout in effect is zero, `timeout_o` never rises, whatever ticks or strobes arrive.
- R3: With a timeout N in effect, `timeout_o` pulses on the Nth tick after the counter was loaded. The counter then reloads itself with N, so the pulse repeats every N ticks until a strobe or new value intervenes.
- R4: A write with bit 7 = 1 reloads the counter with the timeout in effect, so the next pulse comes N ticks after the strobe. A write with bit 7 = 0 leaves the count untouched. Bit 7 always reads as 0.
- R5: The timeout field of a write is staged only if the protect bit (bit 6) was already 0 before that write. The write that clears bit 6 does not stage its field, and while bit 6 is 1 every field value written is ignored.
- R6: A staged timeout becomes the value in effect at the next tick. Reads return the value in effect, not the staged one. At that tick the counter is loaded with the new value and is not decremented.
- R7: A read returns {0, protect bit, timeout in effect} in bits 7, 6 and 5:0.
- R8: `timeout_o` is high for exactly one clock cycle per expiry, and only in the cycle after a clock edge at which `tick_i` was high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | One-cycle enable for each watchdog period |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register read data |
| timeout_o | output | 1 | One-cycle expiry pulse |

## Verification
The in-RTL assertions check four things on every cycle:
- The counter never exceeds the timeout in effect.
- A disabled watchdog stays silent.
- A pulse only follows a tick edge.
- The value in effect changes only at ticks, a protected write never stages a value, and a strobe request is retired the cycle after it is seen.

The bench scenarios are needed for the tick-by-tick position of each expiry. That covers the restart caused by a strobe, the absence of any restart after a plain write, the load-without-decrement at a value change, and the sequence in which clearing the protect bit must come before a field update.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    // Default width of the timeout field, in tick periods.
    parameter int unsigned TMO_W_DEF = 6;

    // What the counter does in one clock cycle.
    typedef enum logic [2:0] {
        ACT_HOLD,
        ACT_APPLY,
        ACT_STROBE,
        ACT_DEC,
        ACT_EXPIRE
    } cnt_act_e;

    // Priority: a new value at a tick beats a strobe, which beats counting.
    function automatic cnt_act_e pick_action(
        input logic apply,
        input logic strobe,
        input logic tick,
        input logic enabled,
        input logic last
    );
        if (apply)
            return ACT_APPLY;
        else if (strobe)
            return ACT_STROBE;
        else if (tick && enabled)
            return last ? ACT_EXPIRE : ACT_DEC;
        else
            return ACT_HOLD;
    endfunction

endpackage

// File: rtl/wdog_ctrl_reg.sv
module wdog_ctrl_reg #(
    parameter int unsigned TMO_W  = wdog_pkg::TMO_W_DEF,
    localparam int unsigned DATA_W = TMO_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              strobe_ack_i,
    output logic              strobe_req_o,
    output logic              apply_o,
    output logic [TMO_W-1:0]  staged_o,
    output logic [TMO_W-1:0]  active_o,
    output logic [DATA_W-1:0] rd_data_o
);
    localparam int unsigned STB_BIT  = DATA_W - 1;
    localparam int unsigned PROT_BIT = DATA_W - 2;

    typedef struct packed {
        logic             strobe;
        logic             prot;
        logic [TMO_W-1:0] tmo;
    } wr_fields_t;

    wr_fields_t       wr_f;
    logic             prot_q;
    logic             pending_q;
    logic             strobe_q;
    logic [TMO_W-1:0] staged_q;
    logic [TMO_W-1:0] active_q;

    always_comb begin
        wr_f.strobe = wr_data_i[STB_BIT];
        wr_f.prot   = wr_data_i[PROT_BIT];
        wr_f.tmo    = wr_data_i[TMO_W-1:0];
    end

    assign apply_o = tick_i & pending_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prot_q    <= 1'b1;
            pending_q <= 1'b0;
            staged_q  <= '0;
            active_q  <= '0;
        end else begin
            if (apply_o) begin
                active_q  <= staged_q;
                pending_q <= 1'b0;
            end
            if (wr_en_i) begin
                prot_q <= wr_f.prot;
                if (!prot_q) begin
                    staged_q  <= wr_f.tmo;
                    pending_q <= 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            strobe_q <= 1'b0;
        else if (wr_en_i && wr_f.strobe)
            strobe_q <= 1'b1;
        else if (strobe_ack_i)
            strobe_q <= 1'b0;
    end

    assign strobe_req_o = strobe_q;
    assign staged_o     = staged_q;
    assign active_o     = active_q;
    assign rd_data_o    = {1'b0, prot_q, active_q};

    // R5
    prot_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && prot_q && !pending_q && !apply_o) |=> !pending_q);

    // R6
    active_only_at_tick_chk: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> $stable(active_q));

    // R4
    strobe_retired_chk: assert property (@(posedge clk) disable iff (rst)
        (strobe_q && !(wr_en_i && wr_f.strobe)) |=> !strobe_q);

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
    import wdog_pkg::*;
#(
    parameter int unsigned TMO_W = wdog_pkg::TMO_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             apply_i,
    input  logic             strobe_i,
    input  logic [TMO_W-1:0] staged_i,
    input  logic [TMO_W-1:0] active_i,
    output logic             strobe_ack_o,
    output logic [TMO_W-1:0] count_o,
    output logic             timeout_o
);
    localparam logic [TMO_W-1:0] CNT_ONE = TMO_W'(1);

    cnt_act_e         act;
    logic [TMO_W-1:0] count_q;
    logic             timeout_q;

    always_comb begin
        act = pick_action(apply_i, strobe_i, tick_i,
                          active_i != '0, count_q <= CNT_ONE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q   <= '0;
            timeout_q <= 1'b0;
        end else begin
            timeout_q <= 1'b0;
            case (act)
                ACT_APPLY:  count_q <= staged_i;
                ACT_STROBE: count_q <= active_i;
                ACT_DEC:    count_q <= count_q - CNT_ONE;
                ACT_EXPIRE: begin
                    count_q   <= active_i;
                    timeout_q <= 1'b1;
                end
                default:    count_q <= count_q;
            endcase
        end
    end

    assign strobe_ack_o = strobe_i;
    assign count_o      = count_q;
    assign timeout_o    = timeout_q;

    // R8
    pulse_after_tick_chk: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> !timeout_q);

    // R4
    strobe_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (strobe_i && !apply_i) |=> (count_q == $past(active_i)));

endmodule

// File: rtl/wdog_strobed.sv
module wdog_strobed #(
    parameter int unsigned TMO_W  = wdog_pkg::TMO_W_DEF,
    localparam int unsigned DATA_W = TMO_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              timeout_o
);
    logic             strobe_req;
    logic             strobe_ack;
    logic             apply;
    logic [TMO_W-1:0] staged;
    logic [TMO_W-1:0] active;
    logic [TMO_W-1:0] count;

    wdog_ctrl_reg #(.TMO_W(TMO_W)) u_reg (
        .clk          (clk),
        .rst          (rst),
        .tick_i       (tick_i),
        .wr_en_i      (wr_en_i),
        .wr_data_i    (wr_data_i),
        .strobe_ack_i (strobe_ack),
        .strobe_req_o (strobe_req),
        .apply_o      (apply),
        .staged_o     (staged),
        .active_o     (active),
        .rd_data_o    (rd_data_o)
    );

    wdog_counter #(.TMO_W(TMO_W)) u_cnt (
        .clk          (clk),
        .rst          (rst),
        .tick_i       (tick_i),
        .apply_i      (apply),
        .strobe_i     (strobe_req),
        .staged_i     (staged),
        .active_i     (active),
        .strobe_ack_o (strobe_ack),
        .count_o      (count),
        .timeout_o    (timeout_o)
    );

    // R2
    disabled_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (active == '0) |=> !timeout_o);

    // R3
    count_bounded_chk: assert property (@(posedge clk) disable iff (rst)
        count <= active);

endmodule

// File: tb/wdog_strobed_bench.sv
module wdog_strobed_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [7:0] wr_data_i = 8'h00;
    logic [7:0] rd_data_o;
    logic       timeout_o;

    int checks = 0;
    int fails  = 0;
    int ticks  = 0;
    int exp_q[$];
    bit done = 1'b0;

    always #10 clk = ~clk;

    wdog_strobed u_wdog_strobed (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (tick_i),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .rd_data_o (rd_data_o),
        .timeout_o (timeout_o)
    );

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_tick();
        tick_i = 1'b1;
        @(posedge clk);
        ticks++;
        @(negedge clk);
        tick_i = 1'b0;
    endtask

    task automatic ticks_n(input int n);
        for (int i = 0; i < n; i++) do_tick();
    endtask

    task automatic reg_write(input logic [7:0] d);
        wr_en_i   = 1'b1;
        wr_data_i = d;
        @(posedge clk);
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Monitor: each observed pulse must match the next expected tick index.
    always @(negedge clk) begin
        if (!rst && timeout_o) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R2/R3 unexpected timeout actual=tick %0d expected=none", ticks);
            end else begin
                int e;
                e = exp_q.pop_front();
                if (e != ticks) begin
                    fails++;
                    $display("FAIL R3/R4/R6 timeout actual=tick %0d expected=tick %0d", ticks, e);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        idle(1);
        // R1 reset state
        check("R1 read", rd_data_o, 8'h40);
        check("R1 timeout", timeout_o, 0);

        // R2 disabled: ticks do nothing
        ticks_n(5);

        // R5 clearing the protect bit does not stage the field (0x00 has field 0 anyway), R7 read
        reg_write(8'h00);
        idle(1);
        check("R7 read after unprotect", rd_data_o, 8'h00);
        ticks_n(3);

        // R6 stage 3; read shows old value until tick
        reg_write(8'h03);
        idle(1);
        check("R6 read before tick", rd_data_o, 8'h00);
        do_tick();
        idle(1);
        check("R6 read after tick", rd_data_o, 8'h03);
        // R3 repeat every 3 ticks
        exp_q.push_back(ticks + 3);
        exp_q.push_back(ticks + 6);
        ticks_n(6);

        // R6 restage 3 with protect: load at next tick restarts count
        reg_write(8'h43);
        exp_q.push_back(ticks + 4);
        ticks_n(4);

        // R4 strobe restarts; R5 field 5 ignored under protect
        ticks_n(2);
        reg_write(8'hC5);
        idle(1);
        check("R4/R5 read after protected strobe", rd_data_o, 8'h43);
        exp_q.push_back(ticks + 3);
        ticks_n(3);

        // R4 write with bit 7 = 0 does not reload
        do_tick();
        reg_write(8'h40);
        exp_q.push_back(ticks + 2);
        ticks_n(2);

        // R4 repeated strobes keep it quiet
        for (int k = 0; k < 5; k++) begin
            ticks_n(2);
            reg_write(8'hC0);
        end
        idle(1);
        check("R4 strobe bit reads 0", rd_data_o[7], 0);

        // R5 unprotect write does not stage 2; next write stages 1
        reg_write(8'h02);
        reg_write(8'h01);
        do_tick();
        idle(1);
        check("R5 field after unprotect sequence", rd_data_o, 8'h01);
        // R8 back-to-back pulses with timeout 1
        exp_q.push_back(ticks + 1);
        exp_q.push_back(ticks + 2);
        ticks_n(2);

        // R2 disable by staging zero; strobes while disabled do nothing
        reg_write(8'h00);
        do_tick();
        reg_write(8'h80);
        ticks_n(6);
        idle(1);
        check("R2 read disabled", rd_data_o, 8'h00);

        // R3 maximum timeout
        reg_write(8'h3F);
        do_tick();
        idle(1);
        check("R3 read max", rd_data_o, 8'h3F);
        exp_q.push_back(ticks + 63);
        ticks_n(63);
        idle(3);
        check("R3 timeout low between ticks", timeout_o, 0);
        check("R3 all expected timeouts seen", exp_q.size(), 0);

        done = 1'b1;
        summary();
    end

endmodule